// File: doc/BRIEF.md
# Layer Instruction Sequencer

This block steps a convolution accelerator through a network one layer at a time. A host processor first writes the per-layer instruction records into a small synchronous RAM. It then pulses `start`. The sequencer reads one record from the RAM as `WORDS` consecutive words and packs them into one wide settings word. It applies that word to the convolution engine and to the padding and pooling units that follow it. It then waits until the engine reports that the layer has finished. Only after that does it fetch the next record.

The RAM has a fixed read latency of `RD_LAT` cycles, so the sequencer needs no read handshake: it counts the returned words itself. The records are laid out back to back from address zero. The run ends after the record whose final bit is set. The RAM keeps its contents, so each later `start` runs the same program again without a reload. The settings word and the layer pulse are plain control pins with no back-pressure. The engine replies with `layer_done` when it is ready for the next layer.

Top module: `layer_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `layer_go` and `mem_rd_en` are 0 and `layer_settings` is all zeros.
- R2: A `start` seen while idle makes the next cycle issue the first of `WORDS` consecutive reads. These reads go to consecutive addresses, one read per cycle.
- R3: RAM word k of a record, counted from the record's first address, appears at `layer_settings[WORD_W*k +: WORD_W]`.
- R4: `layer_go` is a one-cycle pulse, raised in the first cycle in which the new settings are visible. `layer_settings` changes only in a cycle where `layer_go` is 1.
- R5: While a layer is running, no read is issued. After `layer_done`, the next record is read starting at the previous record's base address plus `WORDS`.
- R6: A record whose top bit (`layer_settings` MSB, bit 31 of its last word) is 1 is the last one. The `layer_done` for that layer makes `done` pulse for one cycle with `busy` 0, and no further read follows.
- R7: A `start` that arrives while `busy` is 1 has no effect on the read sequence or on the settings.
- R8: Every start from idle reads from address 0, so a stored program runs again unchanged on a later start.
- R9: A `layer_done` that arrives while no layer is running has no effect. This covers idle and the middle of a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Host trigger that begins a run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when the last layer finishes |
| mem_rd_en | output | 1 | Instruction RAM read strobe |
| mem_addr | output | ADDR_W | Instruction RAM word address |
| mem_rd_data | input | WORD_W | Instruction RAM read data, RD_LAT cycles after the strobe |
| layer_settings | output | WORD_W*WORDS | Settings of the current layer, held for the whole layer |
| layer_go | output | 1 | One-cycle pulse when new settings are applied |
| layer_done | input | 1 | The current layer has finished |

## Verification
The bench runs three patterns. A four-layer program with a distinct value in every word position shows whether words land in the right slices and whether the base address steps correctly between records. The same program is run a second time without reloading the RAM, which separates a true restart from address zero from a continuation. A single-layer program shows whether the last flag on the very first record ends the run. A `start` and a `layer_done` are injected in the middle of a fetch, and a `layer_done` is pulsed while idle. Each of these must leave the address stream and the scoreboard untouched, so a design that reacts to stray control pulses is told apart from one that ignores them.

// File: rtl/lseq_pkg.sv
package lseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_LOAD  = 2'd2,
    ST_RUN   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/lseq_rec_assembler.sv
// Collects the words returned by the RAM into one record.
module lseq_rec_assembler #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 8,
  parameter int RD_LAT = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      rd_issue,
  input  logic [WORD_W-1:0]         rd_data,
  output logic [WORD_W*WORDS-1:0]   rec,
  output logic                      last_word
);
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [RD_LAT-1:0] vld_pipe;
  logic              rsp_vld;
  logic [IDX_W-1:0]  idx;

  // Read-valid delay line matching the RAM latency
  generate
    if (RD_LAT == 1) begin : g_lat1
      always_ff @(posedge clk) begin
        if (!rst_n) vld_pipe <= '0;
        else        vld_pipe <= rd_issue;
      end
    end else begin : g_latn
      always_ff @(posedge clk) begin
        if (!rst_n) vld_pipe <= '0;
        else        vld_pipe <= {vld_pipe[RD_LAT-2:0], rd_issue};
      end
    end
  endgenerate

  assign rsp_vld   = vld_pipe[RD_LAT-1];
  assign last_word = rsp_vld && (idx == IDX_W'(WORDS-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      rec <= '0;
    end else if (clr) begin
      idx <= '0;
    end else if (rsp_vld) begin
      rec[idx*WORD_W +: WORD_W] <= rd_data;
      idx <= idx + IDX_W'(1);
    end
  end

  // R2
  rsp_in_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> !clr);
endmodule

// File: rtl/lseq_fetch_fsm.sv
// Sequencing state machine: read issue, apply, wait for layer end.
module lseq_fetch_fsm
  import lseq_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              layer_done,
  input  logic              last_word,
  input  logic              last_flag,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              clr,
  output logic              load,
  output logic              layer_go,
  output logic              done,
  output logic              busy
);
  localparam int ISS_W = $clog2(WORDS + 1);

  seq_state_e        state;
  logic [ADDR_W-1:0] base;
  logic [ISS_W-1:0]  iss;

  assign rd_en   = (state == ST_FETCH) && (iss != ISS_W'(WORDS));
  assign rd_addr = base + ADDR_W'(iss);
  assign clr     = (state != ST_FETCH);
  assign load    = (state == ST_LOAD);
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      base     <= '0;
      iss      <= '0;
      layer_go <= 1'b0;
      done     <= 1'b0;
    end else begin
      layer_go <= 1'b0;
      done     <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          base  <= '0;
          iss   <= '0;
          state <= ST_FETCH;
        end
        ST_FETCH: begin
          if (rd_en) iss <= iss + ISS_W'(1);
          if (last_word) state <= ST_LOAD;
        end
        ST_LOAD: begin
          layer_go <= 1'b1;
          state    <= ST_RUN;
        end
        ST_RUN: if (layer_done) begin
          if (last_flag) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            base  <= base + ADDR_W'(WORDS);
            iss   <= '0;
            state <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + ADDR_W'(1)));
  // R4
  go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    layer_go |=> !layer_go);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !rd_en));
  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && state != ST_RUN) |=> busy);
endmodule

// File: rtl/layer_seq_ctrl.sv
module layer_seq_ctrl #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 8,
  parameter int ADDR_W = 8,
  parameter int RD_LAT = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  output logic                    busy,
  output logic                    done,
  output logic                    mem_rd_en,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic [WORD_W-1:0]       mem_rd_data,
  output logic [WORD_W*WORDS-1:0] layer_settings,
  output logic                    layer_go,
  input  logic                    layer_done
);
  localparam int REC_W = WORD_W * WORDS;

  logic             clr, load, last_word;
  logic [REC_W-1:0] rec;
  logic [REC_W-1:0] settings_q;

  lseq_fetch_fsm #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .layer_done(layer_done),
    .last_word (last_word),
    .last_flag (settings_q[REC_W-1]),
    .rd_en     (mem_rd_en),
    .rd_addr   (mem_addr),
    .clr       (clr),
    .load      (load),
    .layer_go  (layer_go),
    .done      (done),
    .busy      (busy)
  );

  lseq_rec_assembler #(.WORD_W(WORD_W), .WORDS(WORDS), .RD_LAT(RD_LAT)) u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .rd_issue (mem_rd_en),
    .rd_data  (mem_rd_data),
    .rec      (rec),
    .last_word(last_word)
  );

  // Held settings, updated once per layer
  always_ff @(posedge clk) begin
    if (!rst_n)    settings_q <= '0;
    else if (load) settings_q <= rec;
  end

  assign layer_settings = settings_q;

  // R4
  settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (layer_settings != $past(layer_settings)) |-> layer_go);
  // R8
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (mem_rd_en && mem_addr == '0));
  // R5
  no_read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy);
endmodule

// File: tb/test_layer_seq_ctrl.sv
`timescale 1ns/1ps
module test_layer_seq_ctrl;
  localparam int WORD_W = 32;
  localparam int WORDS  = 8;
  localparam int ADDR_W = 8;
  localparam int REC_W  = WORD_W * WORDS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic layer_done = 1'b0;
  logic busy, done, mem_rd_en, layer_go;
  logic [ADDR_W-1:0] mem_addr;
  logic [WORD_W-1:0] mem_rd_data;
  logic [REC_W-1:0]  layer_settings;

  logic [WORD_W-1:0] ram [0:(1<<ADDR_W)-1];
  logic [REC_W-1:0]  exp_q [$];

  int tests = 0, fails = 0;
  int mon_tests = 0, mon_fails = 0;

  always #2 clk = ~clk;

  layer_seq_ctrl #(.WORD_W(WORD_W), .WORDS(WORDS), .ADDR_W(ADDR_W), .RD_LAT(1)) i_layer_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
    .layer_settings(layer_settings), .layer_go(layer_go), .layer_done(layer_done)
  );

  // RAM model with one-cycle read latency
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= ram[mem_addr];

  function automatic logic [WORD_W-1:0] rec_word(int seed, int l, int k, bit last);
    logic [WORD_W-1:0] w;
    w = (32'h35C3_0000 ^ WORD_W'(seed)) + WORD_W'(l) * 32'h0101_0007 + WORD_W'(k) * 32'h0013_1111;
    w[31] = (k == WORDS-1) ? last : 1'b0;
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [REC_W-1:0] act, input logic [REC_W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // Driver: store a program in the RAM
  task automatic load_prog(int seed, int nl);
    for (int l = 0; l < nl; l++)
      for (int k = 0; k < WORDS; k++)
        ram[l*WORDS + k] = rec_word(seed, l, k, l == nl-1);
  endtask

  // Driver: push the expected records of a run into the scoreboard
  task automatic push_exp(int seed, int nl);
    logic [REC_W-1:0] r;
    for (int l = 0; l < nl; l++) begin
      for (int k = 0; k < WORDS; k++) r[k*WORD_W +: WORD_W] = rec_word(seed, l, k, l == nl-1);
      exp_q.push_back(r);
    end
  endtask

  task automatic run_prog(int nl, int dly, bit poke);
    start = 1'b1; tick(); start = 1'b0;
    if (poke) begin
      tick(); tick();
      start = 1'b1; layer_done = 1'b1;   // R7, R9: stray pulses mid-fetch
      tick();
      start = 1'b0; layer_done = 1'b0;
    end
    for (int l = 0; l < nl; l++) begin
      @(negedge clk);
      while (!layer_go) @(negedge clk);
      for (int d = 0; d < dly; d++) begin
        @(negedge clk);
        check(!mem_rd_en && busy, "R5 no read while layer runs", REC_W'(mem_rd_en), '0);
      end
      tick(); layer_done = 1'b1; tick(); layer_done = 1'b0;
      if (l == nl-1) begin
        @(negedge clk);
        check(done && !busy, "R6 done pulse and idle", REC_W'({done, busy}), REC_W'(2'b10));
        tick(); @(negedge clk);
        check(!done && !mem_rd_en, "R6 single done, no further read", REC_W'({done, mem_rd_en}), '0);
      end
    end
    check(exp_q.size() == 0, "R3 scoreboard drained", REC_W'(exp_q.size()), '0);
  endtask

  // Monitor: address stream and settings scoreboard
  logic [ADDR_W-1:0] exp_addr = '0;
  logic [REC_W-1:0]  prev_set = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (start && !busy) exp_addr = '0;        // R8 restart point
      if (mem_rd_en) begin
        mon_tests++;
        if (mem_addr != exp_addr) begin
          mon_fails++;
          $display("FAIL R2/R5/R7/R8 read address actual=%0d expected=%0d", mem_addr, exp_addr);
        end
        exp_addr = exp_addr + 1'b1;
      end
      if (layer_settings != prev_set) begin
        mon_tests++;
        if (!layer_go) begin
          mon_fails++;
          $display("FAIL R4 settings changed without layer_go actual=%h expected=%h", layer_settings, prev_set);
        end
      end
      if (layer_go) begin
        mon_tests++;
        if (exp_q.size() == 0) begin
          mon_fails++;
          $display("FAIL R3 unexpected layer_go actual=%h expected=none", layer_settings);
        end else begin
          logic [REC_W-1:0] e;
          e = exp_q.pop_front();
          if (layer_settings != e) begin
            mon_fails++;
            $display("FAIL R3 settings actual=%h expected=%h", layer_settings, e);
          end
        end
      end
      prev_set = layer_settings;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests + mon_tests + 1, fails + mon_fails + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1<<ADDR_W); i++) ram[i] = '0;
    repeat (4) tick();
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!busy && !done && !layer_go && !mem_rd_en, "R1 reset outputs",
          REC_W'({busy, done, layer_go, mem_rd_en}), '0);
    check(layer_settings == '0, "R1 reset settings", layer_settings, '0);

    // R9: layer_done while idle
    tick(); layer_done = 1'b1; tick(); layer_done = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!busy && !mem_rd_en, "R9 layer_done idle ignored", REC_W'({busy, mem_rd_en}), '0);
    end

    // Four-layer program, R2 R3 R5 R6
    load_prog(11, 4);
    push_exp(11, 4);
    tick();
    run_prog(4, 3, 1'b0);

    // R8: same program again without reload, stray pulses mid-fetch (R7 R9)
    push_exp(11, 4);
    tick();
    run_prog(4, 0, 1'b1);

    // Single-layer program: last flag on first record (R6)
    load_prog(77, 1);
    push_exp(77, 1);
    tick();
    run_prog(1, 2, 1'b0);
    check(layer_settings[REC_W-1] == 1'b1, "R6 last flag bit held", REC_W'(layer_settings[REC_W-1]), REC_W'(1));

    repeat (3) tick();
    $display("[TB] %0d tests run, %0d failed", tests + mon_tests, fails + mon_fails);
    $finish;
  end
endmodule